// File: doc/BRIEF.md
# NAND Flash Phase Sequencer

This block sits between a memory-mapped bus port and a raw 8-bit NAND flash bus. Every access carries its own plan for the flash cycles in its bus address. That plan holds the phase, the command bytes, the number of address cycles, whether a closing command follows, and whether chip select is released afterwards. No control registers are involved. The sequencer decodes the address of an accepted access and plays out the matching series of flash bus cycles on CLE, ALE, the write and read strobes, the per-device chip selects and the byte-wide data bus.

A command-phase access sends a command byte, then zero to seven address bytes taken from the write data, then an optional closing command byte. A data-phase access first waits for the flash ready input. It then moves one bus word of bytes to or from the flash, and can close with a command byte. Chip select normally stays asserted between accesses, so that one command phase and several data phases form a single flash operation. The final data phase of a page can ask for chip select to be dropped once it completes.

Top module: `nand_phase_seq`

## Requirements
- R1: After reset the block is idle (busy low), every chip select is high, CLE, ALE and the data-bus drive enable are low, and both strobes are high.
- R2: Address bit 19 of an access picks its phase: 0 runs a command phase and 1 runs a data phase.
- R3: A command phase first issues one write strobe with CLE high and ALE low, carrying address bits [10:3] on the data bus.
- R4: After the first byte, a command phase issues N write strobes with ALE high and CLE low, where N is address bits [23:21] (0 to 7). Address byte k is write-data byte (k mod 4), where byte 0 is bits [7:0].
- R5: When address bit 20 is set, in either phase, a final write strobe with CLE high carries address bits [18:11]. When bit 20 is clear, no such byte is sent.
- R6: A data-phase write issues 4 write strobes with CLE and ALE low and drive enable high, carrying write-data bytes 0 to 3 in that order.
- R7: A data-phase read issues 4 read strobes with CLE and ALE low. The byte on the flash bus during strobe k lands in read-data bits [8k+7:8k]. rd_valid pulses for exactly one cycle, in the first idle cycle, with the assembled word.
- R8: Address bits [31:24] name the target device. After an access is accepted, only chip select bit [31:24] is low, and it stays low across later accesses. A device number of NUM_CHIPS or more asserts no chip select. At most one chip select is ever low.
- R9: A data phase with address bit 21 set raises every chip select when it completes. In a command phase, bit 21 is part of the address count and releases nothing.
- R10: A data phase with address bit 10 set pulses ecc_last for one cycle, in the first idle cycle after it. A command phase never pulses it.
- R11: busy is high from the cycle after an access is accepted until its last strobe cycle ends. Requests presented while busy are ignored. While idle, no strobe is active and CLE and ALE are low.
- R12: A data phase issues no strobe while the ready input is low. It starts its first strobe after it sees ready high.
- R13: Each strobe is low for PULSE_W cycles and then high for HOLD_W cycles. CLE, ALE and the data bus hold steady while a strobe is low. The write and read strobes are never low together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Access request, taken when idle |
| req_write | input | 1 | 1 for a write access, 0 for a read |
| req_addr | input | 32 | Bus address carrying the flash cycle plan |
| req_wdata | input | DATA_W | Write data: address bytes or data bytes |
| busy | output | 1 | Sequence in progress |
| rd_valid | output | 1 | One-cycle pulse: read word available |
| rd_data | output | DATA_W | Assembled read word |
| ecc_last | output | 1 | One-cycle pulse: final ECC transfer completed |
| flash_rdy | input | 1 | Flash ready input, high when ready |
| ce_n | output | NUM_CHIPS | Per-device chip selects, active low |
| cle | output | 1 | Command latch enable |
| ale | output | 1 | Address latch enable |
| we_n | output | 1 | Write strobe, active low |
| re_n | output | 1 | Read strobe, active low |
| dq_out | output | 8 | Byte driven onto the flash bus |
| dq_oe | output | 1 | Drive enable for dq_out |
| dq_in | input | 8 | Byte read from the flash bus |

## Verification
The bench builds the block with four chip selects, a 32-bit data word, a two-cycle strobe low time and a one-cycle high time. With a two-cycle low time, the strobe width can be measured and CLE, ALE and the data bus can be checked to stay stable inside a strobe. With four devices, a chip-select switch between accesses and an out-of-range device number can both be reached. Address counts of 0, 1, 5 and 7 cover the empty case, the wrap of byte selection past the fourth byte and the largest count.

// File: rtl/nps_pkg.sv
package nps_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_START = 3'd1,
        ST_ADDR  = 3'd2,
        ST_WAIT  = 3'd3,
        ST_DATA  = 3'd4,
        ST_END   = 3'd5
    } seq_state_e;

    // Fields carried in the bus address of one access
    typedef struct packed {
        logic       is_data;
        logic [7:0] chip;
        logic [7:0] first_cmd;
        logic [2:0] naddr;
        logic       close_en;
        logic [7:0] close_cmd;
        logic       drop_cs;
        logic       ecc_final;
    } plan_t;

endpackage

// File: rtl/nps_addr_decode.sv
module nps_addr_decode
    import nps_pkg::*;
(
    input  logic [31:0] addr,
    output plan_t       plan
);
    logic unused_rsvd;

    always_comb begin
        plan.is_data   = addr[19];
        plan.chip      = addr[31:24];
        plan.first_cmd = addr[10:3];
        plan.close_en  = addr[20];
        plan.close_cmd = addr[18:11];
        // bits [23:21] are an address count only in a command phase
        plan.naddr     = addr[19] ? 3'd0 : addr[23:21];
        plan.drop_cs   = addr[19] & addr[21];
        plan.ecc_final = addr[19] & addr[10];
    end

    assign unused_rsvd = ^{addr[2:0], addr[22]};

endmodule

// File: rtl/nps_strobe_timer.sv
module nps_strobe_timer #(
    parameter int PULSE_W = 1,
    parameter int HOLD_W  = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic strobe_low,
    output logic capture,
    output logic step_last
);
    localparam int STEP_LEN = PULSE_W + HOLD_W;
    localparam int CNT_W    = (STEP_LEN > 1) ? $clog2(STEP_LEN) : 1;

    logic [CNT_W-1:0] cnt_d, cnt_q;

    assign strobe_low = run && (cnt_q < CNT_W'(PULSE_W));
    assign capture    = run && (cnt_q == CNT_W'(PULSE_W - 1));
    assign step_last  = run && (cnt_q == CNT_W'(STEP_LEN - 1));

    always_comb begin
        cnt_d = cnt_q;
        if (!run || step_last) begin
            cnt_d = '0;
        end else begin
            cnt_d = cnt_q + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

endmodule

// File: rtl/nand_phase_seq.sv
module nand_phase_seq
    import nps_pkg::*;
#(
    parameter int NUM_CHIPS = 4,
    parameter int DATA_W    = 32,
    parameter int PULSE_W   = 1,
    parameter int HOLD_W    = 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    input  logic                 req_write,
    input  logic [31:0]          req_addr,
    input  logic [DATA_W-1:0]    req_wdata,
    output logic                 busy,
    output logic                 rd_valid,
    output logic [DATA_W-1:0]    rd_data,
    output logic                 ecc_last,
    input  logic                 flash_rdy,
    output logic [NUM_CHIPS-1:0] ce_n,
    output logic                 cle,
    output logic                 ale,
    output logic                 we_n,
    output logic                 re_n,
    output logic [7:0]           dq_out,
    output logic                 dq_oe,
    input  logic [7:0]           dq_in
);
    localparam int BEATS  = DATA_W / 8;
    localparam int BSEL_W = (BEATS > 1) ? $clog2(BEATS) : 1;
    localparam int IDX_W  = 3;

    typedef struct packed {
        seq_state_e          state;
        plan_t               plan;
        logic                wr;
        logic [DATA_W-1:0]   wdata;
        logic [DATA_W-1:0]   rdata;
        logic [IDX_W-1:0]    idx;
        logic                cs_on;
        logic [7:0]          chip;
        logic                rd_pulse;
        logic                ecc_pulse;
    } seq_t;

    seq_t  s_d, s_q;
    plan_t dec_plan;
    logic  run, strobe_low, capture, step_last;
    logic  finish;
    logic  [7:0] data_byte;
    logic  [BSEL_W-1:0] bsel;

    nps_addr_decode u_decode (
        .addr (req_addr),
        .plan (dec_plan)
    );

    assign run = (s_q.state == ST_START) || (s_q.state == ST_ADDR) ||
                 (s_q.state == ST_DATA)  || (s_q.state == ST_END);

    nps_strobe_timer #(
        .PULSE_W (PULSE_W),
        .HOLD_W  (HOLD_W)
    ) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (run),
        .strobe_low (strobe_low),
        .capture    (capture),
        .step_last  (step_last)
    );

    assign bsel      = s_q.idx[BSEL_W-1:0];
    assign data_byte = s_q.wdata[8*bsel +: 8];

    // next-state computation
    always_comb begin
        s_d           = s_q;
        s_d.rd_pulse  = 1'b0;
        s_d.ecc_pulse = 1'b0;
        finish        = 1'b0;

        case (s_q.state)
            ST_IDLE: begin
                if (req_valid) begin
                    s_d.plan  = dec_plan;
                    s_d.wr    = req_write;
                    s_d.wdata = req_wdata;
                    s_d.rdata = '0;
                    s_d.idx   = '0;
                    s_d.cs_on = 1'b1;
                    s_d.chip  = dec_plan.chip;
                    s_d.state = dec_plan.is_data ? ST_WAIT : ST_START;
                end
            end
            ST_START: begin
                if (step_last) begin
                    s_d.idx = '0;
                    if (s_q.plan.naddr != 3'd0) begin
                        s_d.state = ST_ADDR;
                    end else if (s_q.plan.close_en) begin
                        s_d.state = ST_END;
                    end else begin
                        finish = 1'b1;
                    end
                end
            end
            ST_ADDR: begin
                if (step_last) begin
                    if (s_q.idx == s_q.plan.naddr - 3'd1) begin
                        if (s_q.plan.close_en) begin
                            s_d.state = ST_END;
                        end else begin
                            finish = 1'b1;
                        end
                    end else begin
                        s_d.idx = s_q.idx + IDX_W'(1);
                    end
                end
            end
            ST_WAIT: begin
                if (flash_rdy) begin
                    s_d.idx   = '0;
                    s_d.state = ST_DATA;
                end
            end
            ST_DATA: begin
                if (capture && !s_q.wr) begin
                    s_d.rdata[8*bsel +: 8] = dq_in;
                end
                if (step_last) begin
                    if (s_q.idx == IDX_W'(BEATS - 1)) begin
                        if (s_q.plan.close_en) begin
                            s_d.state = ST_END;
                        end else begin
                            finish = 1'b1;
                        end
                    end else begin
                        s_d.idx = s_q.idx + IDX_W'(1);
                    end
                end
            end
            ST_END: begin
                if (step_last) begin
                    finish = 1'b1;
                end
            end
            default: begin
                s_d.state = ST_IDLE;
            end
        endcase

        if (finish) begin
            s_d.state = ST_IDLE;
            if (s_q.plan.is_data) begin
                s_d.rd_pulse  = !s_q.wr;
                s_d.ecc_pulse = s_q.plan.ecc_final;
                if (s_q.plan.drop_cs) begin
                    s_d.cs_on = 1'b0;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{state: ST_IDLE, plan: '0, wr: 1'b0, wdata: '0,
                     rdata: '0, idx: '0, cs_on: 1'b0, chip: '0,
                     rd_pulse: 1'b0, ecc_pulse: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

    // chip select decode: a device number beyond the range matches none
    for (genvar gi = 0; gi < NUM_CHIPS; gi++) begin : g_cs
        assign ce_n[gi] = !(s_q.cs_on && (s_q.chip == 8'(gi)));
    end

    always_comb begin
        cle    = (s_q.state == ST_START) || (s_q.state == ST_END);
        ale    = (s_q.state == ST_ADDR);
        we_n   = !(strobe_low && ((s_q.state != ST_DATA) || s_q.wr));
        re_n   = !(strobe_low && (s_q.state == ST_DATA) && !s_q.wr);
        dq_oe  = run && ((s_q.state != ST_DATA) || s_q.wr);
        case (s_q.state)
            ST_START: dq_out = s_q.plan.first_cmd;
            ST_END:   dq_out = s_q.plan.close_cmd;
            ST_ADDR,
            ST_DATA:  dq_out = data_byte;
            default:  dq_out = 8'h00;
        endcase
    end

    assign busy     = (s_q.state != ST_IDLE);
    assign rd_valid = s_q.rd_pulse;
    assign rd_data  = s_q.rdata;
    assign ecc_last = s_q.ecc_pulse;

endmodule

// File: rtl/nps_seq_chk.sv
module nps_seq_chk #(
    parameter int NUM_CHIPS = 4
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 busy,
    input logic                 rd_valid,
    input logic                 ecc_last,
    input logic [NUM_CHIPS-1:0] ce_n,
    input logic                 cle,
    input logic                 ale,
    input logic                 we_n,
    input logic                 re_n,
    input logic [7:0]           dq_out
);
    // R8
    cs_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~ce_n));

    // R13
    latch_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(cle && ale));

    // R13
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(!we_n && !re_n));

    // R11
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (we_n && re_n && !cle && !ale));

    // R13
    strobe_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!we_n && $past(!we_n)) |-> ($stable(dq_out) && $stable(cle) && $stable(ale)));

    // R7
    rd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid);

    // R10
    ecc_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ecc_last |-> !busy);

endmodule

bind nand_phase_seq nps_seq_chk #(.NUM_CHIPS(NUM_CHIPS)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .busy     (busy),
    .rd_valid (rd_valid),
    .ecc_last (ecc_last),
    .ce_n     (ce_n),
    .cle      (cle),
    .ale      (ale),
    .we_n     (we_n),
    .re_n     (re_n),
    .dq_out   (dq_out)
);

// File: tb/tb_nand_phase_seq.sv
module tb_nand_phase_seq;
    localparam int NUM_CHIPS = 4;
    localparam int DATA_W    = 32;
    localparam int PULSE_W   = 2;
    localparam int HOLD_W    = 1;
    localparam int NVEC      = 8;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 req_valid = 1'b0;
    logic                 req_write = 1'b0;
    logic [31:0]          req_addr = '0;
    logic [DATA_W-1:0]    req_wdata = '0;
    logic                 busy, rd_valid, ecc_last;
    logic [DATA_W-1:0]    rd_data;
    logic                 flash_rdy = 1'b1;
    logic [NUM_CHIPS-1:0] ce_n;
    logic                 cle, ale, we_n, re_n, dq_oe;
    logic [7:0]           dq_out, dq_in;

    always #2 clk = ~clk;

    nand_phase_seq #(
        .NUM_CHIPS (NUM_CHIPS),
        .DATA_W    (DATA_W),
        .PULSE_W   (PULSE_W),
        .HOLD_W    (HOLD_W)
    ) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .busy(busy),
        .rd_valid(rd_valid), .rd_data(rd_data), .ecc_last(ecc_last),
        .flash_rdy(flash_rdy), .ce_n(ce_n), .cle(cle), .ale(ale),
        .we_n(we_n), .re_n(re_n), .dq_out(dq_out), .dq_oe(dq_oe), .dq_in(dq_in)
    );

    int n_chk = 0;
    int n_fail = 0;

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // flash bus monitor
    logic        log_en = 1'b0;
    int          ev_n = 0;
    logic [10:0] ev [64];
    int          rd_strobes = 0;
    int          rd_idx = 0;
    int          rd_bad = 0;
    int          low_cnt = 0;
    int          low_bad = 0;

    function automatic logic [7:0] pat(input int k);
        return 8'(8'hA5 + k * 8'h1D);
    endfunction

    assign dq_in = pat(rd_idx);

    always @(posedge we_n) begin
        if (log_en && ev_n < 64) begin
            ev[ev_n] = {dq_oe, cle, ale, dq_out};
            ev_n++;
        end
    end

    always @(posedge re_n) begin
        if (log_en) begin
            rd_strobes++;
            rd_idx++;
            if (cle || ale) rd_bad++;
        end
    end

    always @(negedge clk) begin
        if (log_en) begin
            if (!we_n || !re_n) begin
                low_cnt++;
            end else begin
                if (low_cnt != 0 && low_cnt != PULSE_W) low_bad++;
                low_cnt = 0;
            end
        end
    end

    // expected flash bus events derived from the address fields
    logic [10:0] xp [64];
    int          xp_n;

    task automatic build_exp(input logic [31:0] a, input logic [31:0] w, input logic wr);
        xp_n = 0;
        if (!a[19]) begin
            xp[xp_n] = {1'b1, 1'b1, 1'b0, a[10:3]}; xp_n++;
            for (int k = 0; k < int'(a[23:21]); k++) begin
                xp[xp_n] = {1'b1, 1'b0, 1'b1, w[8*(k%4) +: 8]}; xp_n++;
            end
        end else if (wr) begin
            for (int k = 0; k < 4; k++) begin
                xp[xp_n] = {1'b1, 1'b0, 1'b0, w[8*k +: 8]}; xp_n++;
            end
        end
        if (a[20]) begin
            xp[xp_n] = {1'b1, 1'b1, 1'b0, a[18:11]}; xp_n++;
        end
    endtask

    function automatic logic [31:0] mk_cmd(input logic [7:0] chip, input logic [2:0] na,
                                           input logic ev, input logic [7:0] ec,
                                           input logic [7:0] sc);
        return {chip, na, ev, 1'b0, ec, sc, 3'b000};
    endfunction

    function automatic logic [31:0] mk_dat(input logic [7:0] chip, input logic clr,
                                           input logic ev, input logic [7:0] ec,
                                           input logic ecc);
        return {chip, 2'b00, clr, ev, 1'b1, ec, ecc, 10'b0};
    endfunction

    // {write, address, write data}
    localparam logic [64:0] VEC [NVEC] = '{
        {1'b1, mk_cmd(8'd0, 3'd1, 1'b0, 8'h00, 8'h90), 32'h0000_0021},
        {1'b1, mk_cmd(8'd1, 3'd5, 1'b1, 8'h30, 8'h00), 32'h4433_2211},
        {1'b0, mk_dat(8'd1, 1'b0, 1'b0, 8'h00, 1'b0), 32'h0},
        {1'b1, mk_dat(8'd1, 1'b1, 1'b1, 8'h10, 1'b1), 32'hDEAD_BEEF},
        {1'b1, mk_cmd(8'd2, 3'd0, 1'b1, 8'h70, 8'hFF), 32'h0},
        {1'b1, mk_cmd(8'd3, 3'd7, 1'b0, 8'h00, 8'h80), 32'h0C0B_0A09},
        {1'b0, mk_dat(8'd3, 1'b1, 1'b1, 8'hE0, 1'b1), 32'h0},
        {1'b1, mk_dat(8'd9, 1'b0, 1'b0, 8'h00, 1'b0), 32'h5566_7788}
    };

    int wait_fail = 0;

    task automatic start_access(input logic [31:0] a, input logic [31:0] w, input logic wr);
        ev_n = 0; rd_strobes = 0; rd_idx = 0; rd_bad = 0;
        log_en = 1'b1;
        @(negedge clk);
        req_valid = 1'b1; req_addr = a; req_wdata = w; req_write = wr;
        @(negedge clk);
        req_valid = 1'b0;
        check("R11 busy after accept", 64'(busy), 64'd1);
    endtask

    task automatic wait_idle();
        int t = 0;
        while (busy && t < 2000) begin
            @(negedge clk);
            t++;
        end
        if (busy) begin
            wait_fail++;
            check("R11 sequence completes", 64'd0, 64'd1);
        end
    endtask

    task automatic finish_checks(input logic [31:0] a, input logic [31:0] w, input logic wr,
                                 input string tag);
        logic [NUM_CHIPS-1:0] exp_ce;
        logic [31:0] exp_rd;
        build_exp(a, w, wr);
        check({tag, " R2 R3 R4 R5 R6 event count"}, 64'(ev_n), 64'(xp_n));
        for (int k = 0; k < xp_n && k < ev_n; k++)
            check({tag, " R3 R4 R5 R6 event"}, 64'(ev[k]), 64'(xp[k]));
        check({tag, " R7 read strobes"}, 64'(rd_strobes), (a[19] && !wr) ? 64'd4 : 64'd0);
        check({tag, " R7 read latches low"}, 64'(rd_bad), 64'd0);
        check({tag, " R7 rd_valid"}, 64'(rd_valid), 64'(a[19] && !wr));
        if (a[19] && !wr) begin
            exp_rd = {pat(3), pat(2), pat(1), pat(0)};
            check({tag, " R7 rd_data"}, 64'(rd_data), 64'(exp_rd));
        end
        check({tag, " R10 ecc_last"}, 64'(ecc_last), 64'(a[19] && a[10]));
        exp_ce = '1;
        if (!(a[19] && a[21]) && int'(a[31:24]) < NUM_CHIPS) exp_ce[a[25:24]] = 1'b0;
        check({tag, " R8 R9 chip select"}, 64'(ce_n), 64'(exp_ce));
        check({tag, " R13 strobe width"}, 64'(low_bad), 64'd0);
        log_en = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 busy", 64'(busy), 64'd0);
        check("R1 ce_n", 64'(ce_n), 64'hF);
        check("R1 cle ale oe", 64'({cle, ale, dq_oe}), 64'd0);
        check("R1 strobes", 64'({we_n, re_n}), 64'h3);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 idle after release", 64'({busy, rd_valid, ecc_last}), 64'd0);

        // table walk
        for (int i = 0; i < NVEC; i++) begin
            start_access(VEC[i][63:32], VEC[i][31:0], VEC[i][64]);
            wait_idle();
            finish_checks(VEC[i][63:32], VEC[i][31:0], VEC[i][64], $sformatf("vec%0d", i));
        end

        // R12: data phase held off while the flash is not ready
        flash_rdy = 1'b0;
        start_access(mk_dat(8'd0, 1'b0, 1'b0, 8'h00, 1'b0), 32'h0, 1'b0);
        repeat (10) @(negedge clk);
        check("R12 no strobe while not ready", 64'(rd_strobes + ev_n), 64'd0);
        check("R12 busy while not ready", 64'(busy), 64'd1);
        flash_rdy = 1'b1;
        wait_idle();
        finish_checks(mk_dat(8'd0, 1'b0, 1'b0, 8'h00, 1'b0), 32'h0, 1'b0, "R12 resume");

        // R11: a request arriving while busy is dropped
        start_access(mk_cmd(8'd2, 3'd2, 1'b0, 8'h00, 8'h60), 32'h0000_BBAA, 1'b1);
        req_valid = 1'b1;
        req_addr  = mk_dat(8'd1, 1'b1, 1'b0, 8'h00, 1'b1);
        req_wdata = 32'h1234_5678;
        req_write = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        wait_idle();
        finish_checks(mk_cmd(8'd2, 3'd2, 1'b0, 8'h00, 8'h60), 32'h0000_BBAA, 1'b1, "R11 drop");
        repeat (4) @(negedge clk);
        check("R11 stays idle after drop", 64'(busy), 64'd0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule